// File: doc/BRIEF.md
# Serial ADC Device-Side Port

This block implements, in synchronous logic, the digital side of a two-channel serial converter's port. A host drives an active-low select (`csN`), a serial clock (`sclk`) and a serial data line (`sdi`). All three are sampled by the system clock, and a rising `sclk` is recognized as a low-to-high change between two system cycles. The analog front end is replaced by a parallel `sampleData` word. The block latches that word at the moment a conversion would begin, then returns it on `sdo`.

In four-wire operation, the block waits for a start bit and then reads a four-bit command. The first two command bits choose the measurement: `muxSgl`=1 means single-ended against ground, and `muxSgl`=0 means a differential pair. When single-ended, `muxOdd` names the channel; when differential, it names which input is positive. The last two command bits are padding that covers acquisition. In three-wire operation there is no command, and the first serial clock starts the reply directly. In both modes the reply is two zero framing bits, then the sample MSB first, then zeros for as long as clocks continue. `sdoEn` models the tri-state control of the data line.

Top module: `serial_adc_port`

## Requirements
- R1: While `csN` is high, the exchange is abandoned. On the system cycle after `csN` is seen high, `sdoEn`, `sdo`, `muxSgl` and `muxOdd` are all 0. The next low period of `csN` starts a fresh start-bit search.
- R2: In four-wire mode (`threeWire`=0), every 0 sampled on `sdi` at a rising `sclk` before the first 1 is ignored, and `sdoEn` stays 0.
- R3: The first 1 on `sdi` is the start bit. The next rising edge stores `sdi` into `muxSgl`, and the edge after that stores `sdi` into `muxOdd`. Both values hold until `csN` rises.
- R4: The fourth rising `sclk` after the start bit makes `sampleGrab` 1 for exactly that one system cycle, captures `sampleData`, and sets `sdoEn`=1 with `sdo`=0 (first framing bit).
- R5: On the following rising `sclk` edges, `sdo` presents a second 0 and then the W sample bits, MSB first, one bit per edge. `sdo` and `sdoEn` change only on a rising `sclk` or when `csN` is high.
- R6: After the sample's LSB, each further rising `sclk` with `csN` low drives `sdo`=0, and `sdoEn` stays 1.
- R7: Once the four command bits have been taken, `sdi` has no effect until `csN` rises: `muxSgl`, `muxOdd` and the reply are unchanged by it.
- R8: In three-wire mode (`threeWire`=1), the first rising `sclk` after `csN` falls captures the sample, pulses `sampleGrab`, and enables `sdo` with the first framing 0. No `sdi` bits are read, and `muxSgl` and `muxOdd` stay 0.
- R9: Changes on `sampleData` after the capture cycle do not alter the shifted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock level, sampled by `clk` |
| sdi | input | 1 | Serial command data from the host |
| threeWire | input | 1 | 1 selects command-less operation |
| sampleData | input | W | Parallel conversion value |
| sdo | output | 1 | Serial reply bit |
| sdoEn | output | 1 | Drive enable for `sdo` (0 models high impedance) |
| sampleGrab | output | 1 | High in the cycle `sampleData` is captured |
| muxSgl | output | 1 | Latched single-ended/differential select |
| muxOdd | output | 1 | Latched channel or polarity select |

## Verification
Three events land on the same rising serial clock: the last command bit is taken, `sampleData` is captured, and the output is enabled with its first framing zero. The bench checks that `sampleGrab`, `sdoEn` and a zero on `sdo` all appear together on that edge. It then inverts `sampleData` immediately after the edge. Every shifted bit is compared against the value held before the inversion, so a capture made one edge late, or a live path from the input, shows up as a mismatch. The bench also raises `csN` partway through an exchange. A following search has to ignore leading zeros again and report a freshly read command.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_CONFIG = 2'd1,
    ST_OUTPUT = 2'd2
  } sadcState_t;

  typedef struct packed {
    logic clear;
    logic latch;
    logic shift;
    logic takeSgl;
    logic takeOdd;
  } sadcStrobes_t;
endpackage

// File: rtl/serial_adc_ctrl.sv
`timescale 1ns/1ps
module serial_adc_ctrl
  import sadc_pkg::*;
#(
  parameter int CFG_BITS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         threeWire,
  output sadcStrobes_t strb
);
  localparam int CW = $clog2(CFG_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(CFG_BITS - 1);

  sadcState_t    state;
  logic [CW-1:0] cfgCnt;
  logic          sclkPrev;
  logic          sclkRise;
  logic          edgeLive;

  assign sclkRise = sclk & ~sclkPrev;
  assign edgeLive = sclkRise & ~csN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ARMED;
      cfgCnt   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (csN) begin
        state  <= ST_ARMED;
        cfgCnt <= '0;
      end else if (sclkRise) begin
        unique case (state)
          ST_ARMED: begin
            if (threeWire) begin
              state <= ST_OUTPUT;
            end else if (sdi) begin
              state  <= ST_CONFIG;
              cfgCnt <= '0;
            end
          end
          ST_CONFIG: begin
            if (cfgCnt == LAST_IDX) state <= ST_OUTPUT;
            cfgCnt <= cfgCnt + 1'b1;
          end
          ST_OUTPUT: state <= ST_OUTPUT;
          default:   state <= ST_ARMED;
        endcase
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.clear   = csN;
    strb.latch   = edgeLive & (((state == ST_ARMED) & threeWire) |
                               ((state == ST_CONFIG) & (cfgCnt == LAST_IDX)));
    strb.shift   = edgeLive & (state == ST_OUTPUT);
    strb.takeSgl = edgeLive & (state == ST_CONFIG) & (cfgCnt == '0);
    strb.takeOdd = edgeLive & (state == ST_CONFIG) & (cfgCnt == CW'(1));
  end
endmodule

// File: rtl/serial_adc_dp.sv
`timescale 1ns/1ps
module serial_adc_dp
  import sadc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  sadcStrobes_t strb,
  input  logic         sdi,
  input  logic [W-1:0] sampleData,
  output logic         sdo,
  output logic         sdoEn,
  output logic         muxSgl,
  output logic         muxOdd
);
  // one leading framing zero ahead of the sample; zeros shift in behind it
  logic [W:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
      sdoEn    <= 1'b0;
      muxSgl   <= 1'b0;
      muxOdd   <= 1'b0;
    end else if (strb.clear) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
      sdoEn    <= 1'b0;
      muxSgl   <= 1'b0;
      muxOdd   <= 1'b0;
    end else begin
      if (strb.takeSgl) muxSgl <= sdi;
      if (strb.takeOdd) muxOdd <= sdi;
      if (strb.latch) begin
        shiftReg <= {1'b0, sampleData};
        sdo      <= 1'b0;
        sdoEn    <= 1'b1;
      end else if (strb.shift) begin
        sdo      <= shiftReg[W];
        shiftReg <= {shiftReg[W-1:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/serial_adc_port.sv
`timescale 1ns/1ps
module serial_adc_port
  import sadc_pkg::*;
#(
  parameter int W        = 8,
  parameter int CFG_BITS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         threeWire,
  input  logic [W-1:0] sampleData,
  output logic         sdo,
  output logic         sdoEn,
  output logic         sampleGrab,
  output logic         muxSgl,
  output logic         muxOdd
);
  sadcStrobes_t strb;

  serial_adc_ctrl #(.CFG_BITS(CFG_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .threeWire (threeWire),
    .strb      (strb)
  );

  serial_adc_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sdi        (sdi),
    .sampleData (sampleData),
    .sdo        (sdo),
    .sdoEn      (sdoEn),
    .muxSgl     (muxSgl),
    .muxOdd     (muxOdd)
  );

  assign sampleGrab = strb.latch;
endmodule

// File: rtl/serial_adc_port_chk.sv
`timescale 1ns/1ps
module serial_adc_port_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic threeWire,
  input logic sdo,
  input logic sdoEn,
  input logic sampleGrab,
  input logic muxSgl,
  input logic muxOdd
);
  logic sclkSeen;
  logic riseNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkSeen <= 1'b0;
    else       sclkSeen <= sclk;
  end
  assign riseNow = sclk & ~sclkSeen;

  assert_cs_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!sdoEn && !sdo && !muxSgl && !muxOdd));

  assert_grab_enables_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleGrab |=> (sdoEn && !sdo && !sampleGrab));

  assert_grab_on_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleGrab |-> (riseNow && !csN));

  assert_sdo_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!riseNow && !csN) |=> ($stable(sdo) && $stable(sdoEn)));

  assert_enable_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && !csN) |=> sdoEn);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && !csN) |=> ($stable(muxSgl) && $stable(muxOdd)));

  assert_no_cfg_3wire_R8: assert property (@(posedge clk) disable iff (!rstN)
    (threeWire && sdoEn) |-> (!muxSgl && !muxOdd));
endmodule

bind serial_adc_port serial_adc_port_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .sclk       (sclk),
  .threeWire  (threeWire),
  .sdo        (sdo),
  .sdoEn      (sdoEn),
  .sampleGrab (sampleGrab),
  .muxSgl     (muxSgl),
  .muxOdd     (muxOdd)
);

// File: tb/serial_adc_port_tb.sv
`timescale 1ns/1ps
module serial_adc_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         csN = 1'b1;
  logic         sclk = 1'b0;
  logic         sdi = 1'b0;
  logic         threeWire = 1'b0;
  logic [W-1:0] sampleData = '0;
  logic         sdo, sdoEn, sampleGrab, muxSgl, muxOdd;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic grabSeen, sdoGot, enGot;

  always #4 clk = ~clk;

  serial_adc_port #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .threeWire(threeWire), .sampleData(sampleData), .sdo(sdo),
    .sdoEn(sdoEn), .sampleGrab(sampleGrab), .muxSgl(muxSgl), .muxOdd(muxOdd)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic d);
    @(negedge clk);
    sdi  = d;
    sclk = 1'b1;
    #1 grabSeen = sampleGrab;
    @(negedge clk);
    sdoGot = sdo;
    enGot  = sdoEn;
    sclk   = 1'b0;
    @(negedge clk);
  endtask

  task automatic exchange(input bit tw, input bit sgl, input bit odd,
                          input int zeros, input logic [W-1:0] smp);
    logic [W-1:0] got;
    @(negedge clk);
    csN = 1'b1; threeWire = tw; sampleData = smp;
    repeat (2) @(negedge clk);
    csN = 1'b0;
    @(negedge clk);
    if (!tw) begin
      for (int z = 0; z < zeros; z++) begin
        pulse(1'b0);
        chk(!enGot && !grabSeen, "R2 leading zero ignored", enGot, 0);
      end
      pulse(1'b1);
      chk(!enGot && !grabSeen, "R3 start bit only", enGot, 0);
      pulse(sgl);
      pulse(odd);
      pulse(1'b1);
      chk(!enGot && !grabSeen, "R4 not yet enabled", enGot, 0);
      pulse(1'b0);
      chk(grabSeen, "R4 grab on fourth edge", grabSeen, 1);
      chk(enGot && !sdoGot, "R4 enable and first null", {enGot, sdoGot}, 2'b10);
    end else begin
      pulse(1'b1);
      chk(grabSeen && enGot && !sdoGot, "R8 first clock enables",
          {grabSeen, enGot, sdoGot}, 3'b110);
    end
    sampleData = ~smp;  // R9: must not leak into the result
    pulse(1'b1);
    chk(enGot && !sdoGot, "R5 second null", {enGot, sdoGot}, 2'b10);
    for (int i = 0; i < W; i++) begin
      pulse(logic'(i[0]));
      got[W-1-i] = sdoGot;
    end
    chk(got == smp, "R5 R9 result MSB first", got, smp);
    for (int k = 0; k < 3; k++) begin
      pulse(1'b1);
      chk(enGot && !sdoGot, "R6 zero fill", {enGot, sdoGot}, 2'b10);
    end
    chk({muxSgl, muxOdd} == (tw ? 2'b00 : {sgl, odd}), "R3 R7 R8 mux config",
        {muxSgl, muxOdd}, tw ? 2'b00 : {sgl, odd});
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
    chk(!sdoEn && !sdo && !muxSgl && !muxOdd, "R1 release",
        {sdoEn, sdo, muxSgl, muxOdd}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!sdoEn && !sdo && !sampleGrab && !muxSgl && !muxOdd, "R1 reset state",
        {sdoEn, sdo, sampleGrab, muxSgl, muxOdd}, 0);

    // four-wire sweep: every command, 0..3 leading zeros, several samples
    for (int c = 0; c < 4; c++)
      for (int z = 0; z < 4; z++)
        for (int k = 0; k < 6; k++) begin
          logic [W-1:0] s;
          s = (k == 0) ? '0 : (k == 1) ? '1 : W'((k * 53 + c * 17 + z * 5) % 256);
          exchange(1'b0, c[1], c[0], z, s);
        end

    // three-wire sweep over every sample value
    for (int v = 0; v < (1 << W); v++) exchange(1'b1, 1'b0, 1'b0, 0, W'(v));

    // abort mid-reply, then a fresh search must ignore zeros again
    @(negedge clk); csN = 1'b1; threeWire = 1'b0; sampleData = 8'hA5;
    repeat (2) @(negedge clk); csN = 1'b0;
    pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b0);
    pulse(1'b1); pulse(1'b1);
    chk(enGot && muxSgl && muxOdd, "R1 exchange running", {enGot, muxSgl, muxOdd}, 3'b111);
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
    chk(!sdoEn && !muxSgl && !muxOdd, "R1 abort clears", {sdoEn, muxSgl, muxOdd}, 0);
    csN = 1'b0;
    pulse(1'b0); pulse(1'b0);
    chk(!enGot, "R1 R2 fresh hunt", enGot, 0);

    // abort partway through the command, then a clean exchange
    @(negedge clk); csN = 1'b1;
    repeat (2) @(negedge clk); csN = 1'b0;
    pulse(1'b1); pulse(1'b1);
    exchange(1'b0, 1'b0, 1'b1, 1, 8'h3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule